// File: doc/BRIEF.md
# Triggered 16-Byte DMA Burst Requester

This block is the peripheral-side request logic that lets a storage card move data through a system DMA controller in short bursts. Software starts each burst by writing to a control strobe; the value written does not matter. The block then raises its DMA request and keeps it high while the controller performs up to sixteen single-byte transfers, each marked by one acknowledge strobe. After the sixteenth transfer the request drops, so the CPU and other requesters, such as memory refresh, can take the bus before the next burst.

A terminal-count indication from the controller ends the burst early. The count is only seen together with an acknowledge. Software therefore issues one trigger for every sixteen bytes, rounding up, and a short final chunk is ended by terminal count. Nothing else can cut a burst short. Each acknowledged transfer gives one enable pulse toward a byte FIFO: a read enable when data moves to memory and a write enable when data comes from memory. The data bytes pass straight between the bus and the FIFO.

Top module: `dma_burst_req`

## Requirements
- R1: After reset, `drq`, `busy`, `fifo_rd_en` and `fifo_wr_en` are all 0.
- R2: A cycle with `ctl_wr` high while `drq` is 0 sets `drq` to 1 from the next clock edge on.
- R3: Once raised, `drq` falls at the clock edge that ends the cycle of the sixteenth cycle with `dack` high, if no terminal count came first.
- R4: A cycle with `dack` and `tc` both high while `drq` is 1 ends the burst: `drq` is 0 from the next edge on. That transfer still gets its enable pulse. A `tc` without `dack` has no effect.
- R5: `ctl_wr` while `drq` is 1 is ignored. It neither extends nor restarts the burst, so the burst still ends after sixteen transfers counted from its start.
- R6: In each cycle with `dack` high while `drq` is 1, exactly one enable is high for that cycle: `fifo_rd_en` when `dir_to_mem` is 1, or `fifo_wr_en` when `dir_to_mem` is 0. Neither enable is high in any other cycle.
- R7: `busy` equals `drq` in every cycle.
- R8: `dack` while `drq` is 0 produces no enable and does not raise `drq`.
- R9: `bus_dout` always equals `fifo_rdata`, and `fifo_wdata` always equals `bus_din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe; starts a burst |
| dir_to_mem | input | 1 | 1: data moves card-to-memory; 0: memory-to-card |
| dack | input | 1 | DMA acknowledge, one cycle per byte transfer |
| tc | input | 1 | Terminal count from the DMA controller |
| drq | output | 1 | DMA request |
| busy | output | 1 | Status: burst in progress |
| fifo_rd_en | output | 1 | Pop one byte from the FIFO onto the bus |
| fifo_wr_en | output | 1 | Push one byte from the bus into the FIFO |
| fifo_rdata | input | 8 | FIFO output byte |
| fifo_wdata | output | 8 | Byte pushed into the FIFO |
| bus_din | input | 8 | Byte from the system bus |
| bus_dout | output | 8 | Byte driven to the system bus |

## Verification
The hardest situation to reach is a trigger that arrives in the middle of a burst. Its effect only shows later, as a request that lasts too long or restarts its count. The stimulus places trigger writes between acknowledges, on the cycle of the final acknowledge, and during gaps with no acknowledge. The reference model must then show the request dropping after exactly sixteen transfers counted from the original start. Terminal count is placed on the first, a middle, and the last transfer, and also without an acknowledge.

// File: rtl/dma_burst_req.sv
module dma_burst_req #(
  parameter int BURST_LEN = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          dir_to_mem,
  input  logic          dack,
  input  logic          tc,
  output logic          drq,
  output logic          busy,
  output logic          fifo_rd_en,
  output logic          fifo_wr_en,
  input  logic [DW-1:0] fifo_rdata,
  output logic [DW-1:0] fifo_wdata,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout
);
  localparam int CW = $clog2(BURST_LEN);
  localparam logic [CW-1:0] LAST = CW'(BURST_LEN - 1);

  logic [CW-1:0] cnt;
  logic xfer, done;

  assign xfer = drq & dack;
  assign done = xfer & (tc | (cnt == LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drq <= 1'b0;
      cnt <= '0;
    end else if (!drq) begin
      if (ctl_wr) begin
        drq <= 1'b1;
        cnt <= '0;
      end
    end else if (xfer) begin
      cnt <= cnt + 1'b1;
      if (done) drq <= 1'b0;
    end
  end

  assign busy       = drq;
  assign fifo_rd_en = xfer & dir_to_mem;
  assign fifo_wr_en = xfer & ~dir_to_mem;
  assign bus_dout   = fifo_rdata;
  assign fifo_wdata = bus_din;

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drq) |-> $past(ctl_wr));
  p_drop_on_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drq) |-> $past(dack));
  p_tc_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && dack && tc) |=> !drq);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && !dack) |=> drq);
  p_en_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_rd_en, fifo_wr_en}));
  p_en_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd_en || fifo_wr_en) |-> (drq && dack));
endmodule

// File: tb/dma_burst_req_tb.sv
`timescale 1ns/1ps
module dma_burst_req_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, dir_to_mem = 1'b0, dack = 1'b0, tc = 1'b0;
  logic drq, busy, fifo_rd_en, fifo_wr_en;
  logic [7:0] fifo_rdata = 8'h00, bus_din = 8'h00, fifo_wdata, bus_dout;

  int checks = 0;
  int errors = 0;
  int m_drq = 0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  dma_burst_req dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .dir_to_mem(dir_to_mem),
    .dack(dack), .tc(tc), .drq(drq), .busy(busy),
    .fifo_rd_en(fifo_rd_en), .fifo_wr_en(fifo_wr_en),
    .fifo_rdata(fifo_rdata), .fifo_wdata(fifo_wdata),
    .bus_din(bus_din), .bus_dout(bus_dout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int e_rd, e_wr;
    e_rd = (m_drq != 0 && dack && dir_to_mem) ? 1 : 0;
    e_wr = (m_drq != 0 && dack && !dir_to_mem) ? 1 : 0;
    chk("R3 drq", int'(drq), m_drq);
    chk("R7 busy", int'(busy), m_drq);
    chk("R6 fifo_rd_en", int'(fifo_rd_en), e_rd);
    chk("R6 fifo_wr_en", int'(fifo_wr_en), e_wr);
    chk("R9 bus_dout", int'(bus_dout), int'(fifo_rdata));
    chk("R9 fifo_wdata", int'(fifo_wdata), int'(bus_din));
  endtask

  task automatic step(input logic w, input logic a, input logic t, input logic d);
    @(negedge clk);
    ctl_wr = w; dack = a; tc = t; dir_to_mem = d;
    fifo_rdata = 8'($urandom); bus_din = 8'($urandom);
    #1;
    compare_all();
    @(posedge clk);
    if (m_drq != 0) begin
      if (a) begin
        m_cnt++;
        if (m_cnt == 16 || t) m_drq = 0;
      end
    end else if (w) begin
      m_drq = 1;
      m_cnt = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 drq after reset", int'(drq), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 enables after reset", int'(fifo_rd_en | fifo_wr_en), 0);

    // R8: acknowledges and tc while idle
    for (int i = 0; i < 4; i++) step(0, 1, i[0], i[1]);
    chk("R8 drq stays low", int'(drq), 0);

    // R2 + R3: full burst, card to memory, back-to-back acks
    step(1, 0, 0, 1);
    #1 chk("R2 drq raised", int'(drq), 1);
    for (int i = 0; i < 16; i++) step(0, 1, 0, 1);
    #1 chk("R3 drq low after 16", int'(drq), 0);
    idle(2);

    // R5: memory-to-card with gaps and stray triggers
    step(1, 0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      step(i % 3 == 0, 1, 0, 0);
      if (i % 4 == 1) step(1, 0, 0, 0);
    end
    #1 chk("R5 trigger ignored, burst ends at 16", int'(drq), 0);
    idle(2);

    // R5: trigger on last ack cycle
    step(1, 0, 0, 1);
    for (int i = 0; i < 15; i++) step(0, 1, 0, 1);
    step(1, 1, 0, 1);
    #1 chk("R5 trigger on final ack ignored", int'(drq), 0);
    idle(1);

    // R4: tc on 5th transfer, tc without ack earlier
    step(1, 0, 0, 0);
    step(0, 0, 1, 0);
    #1 chk("R4 tc without dack ignored", int'(drq), 1);
    for (int i = 0; i < 5; i++) step(0, 1, i == 4, 0);
    #1 chk("R4 tc ends burst", int'(drq), 0);
    idle(1);

    // R4: tc on first transfer and on 16th
    step(1, 0, 0, 1);
    step(0, 1, 1, 1);
    #1 chk("R4 tc on first transfer", int'(drq), 0);
    step(1, 0, 0, 1);
    for (int i = 0; i < 16; i++) step(0, 1, i == 15, 1);
    #1 chk("R4 tc on 16th transfer", int'(drq), 0);

    // several consecutive software-triggered chunks
    for (int b = 0; b < 4; b++) begin
      step(1, 0, 0, b[0]);
      for (int i = 0; i < 16; i++) step(0, ($urandom % 4) != 0, 0, b[0]);
      while (m_drq != 0) step(0, 1, 0, b[0]);
      idle(1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule